// File: doc/BRIEF.md
# Interval Timer with Cycle and Microsecond Time Bases

This peripheral keeps two free-running 64-bit clocks: one counts clock cycles and one counts microseconds, the latter advanced by a prescaler that divides the core clock by `CLK_MHZ`. Software sees both clocks through four 32-bit word registers on a plain address/read/write bus. Reading a low word captures the matching high word in a shadow register, so a low-then-high read pair always forms one coherent 64-bit sample, even if a carry ripples into the upper half between the two reads.

The same four registers program a single one-shot alarm. A write to a low word is held as a pending value. The following write to the high word of the same time base joins both halves into the alarm and arms it. When the chosen clock reaches or passes the alarm, the interrupt line rises and stays high until software acknowledges it or arms a new alarm. After an acknowledge the alarm stays disarmed, so it never fires periodically.

The alarm controller is a three-state machine. In IDLE nothing is armed. In ARMED the chosen clock is compared with the alarm. In FIRED the interrupt is raised. The transitions are: IDLE to ARMED on arm (a high-word write); ARMED to ARMED on arm (reprogram); ARMED to FIRED on reach (chosen clock greater than or equal to the alarm); FIRED to ARMED on arm; FIRED to IDLE on acknowledge. When an arm and an acknowledge arrive in the same cycle, the arm wins.

Top module: `rtc_timer`

## Requirements
- R1: The cycle clock starts at parameter `CYC_INIT` and adds one on every clock edge after reset. Its low word is at byte offset 0x0 and its high word at 0x4.
- R2: The microsecond clock starts at zero and adds one on every `CLK_MHZ`-th clock edge after reset, so after E edges it holds floor(E/CLK_MHZ). Its low word is at offset 0x8 and its high word at 0xC.
- R3: Reading a low word stores the high half of that same clock, as it is at that moment, in a shadow register. Reading the high word returns that shadow, not the live value.
- R4: A write to a low word (0x0 or 0x8) only stores a pending value. It does not arm the alarm and does not change `irq`.
- R5: A write to a high word (0x4 or 0xC) arms an alarm of {written data, pending low word of that base} in that time base. It clears a raised `irq`.
- R6: While the alarm is armed, `irq` rises on the clock edge that follows a cycle in which the chosen clock is greater than or equal to the alarm. This includes an alarm value that is already in the past.
- R7: Once raised, `irq` stays high until `irq_ack` or a new high-word write. After an acknowledge the alarm is disarmed and does not fire again.
- R8: `rdata` is registered and updates only in the cycle after `rd_en`. Accesses with `addr[1:0]` not zero are ignored. After reset `irq` and `rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Byte offset of the accessed word |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| irq_ack | input | 1 | Acknowledge that lowers `irq` and disarms the alarm |
| irq | output | 1 | Alarm interrupt request |

## Verification
The hardest case to reach is a carry from the low 32 bits of the cycle clock into the high 32 bits that falls between a low read and the high read after it. From reset, this needs billions of cycles. The bench therefore overrides `CYC_INIT` with a value 128 cycles below the boundary. It reads the low word before the carry and the high word after it, then repeats the pair once the carry has happened. Because the clock is then already past 2^32, an alarm whose upper half is zero lies in the past. This gives the immediate-fire case for free, and the bench can still predict exact firing edges for future alarms in both time bases from its own edge count.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int ADDR_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_FIRED = 2'd2
    } alarm_state_t;

    typedef enum logic {
        BASE_CYC = 1'b0,
        BASE_US  = 1'b1
    } tbase_t;

    // Word decode: addr[3] picks the time base, addr[2] picks the high half.
    localparam int BASE_BIT = 3;
    localparam int HALF_BIT = 2;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = $clog2(DIV + 1);
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (!rst_n)           pre_q <= '0;
        else if (pre_q == LAST) pre_q <= '0;
        else                  pre_q <= pre_q + PW'(1);
    end

    assign tick = (pre_q == LAST);
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
    parameter int W = 64,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    output logic [W-1:0] value
);
    always_ff @(posedge clk) begin
        if (!rst_n)  value <= INIT;
        else if (en) value <= value + W'(1);
    end
endmodule

// File: rtl/rtc_alarm_fsm.sv
module rtc_alarm_fsm
    import rtc_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         arm,
    input  tbase_t       arm_base,
    input  logic [W-1:0] arm_value,
    input  logic         ack,
    input  logic [W-1:0] cyc,
    input  logic [W-1:0] us,
    output logic         irq
);
    alarm_state_t state_q, state_d;
    logic [W-1:0] alarm_q;
    tbase_t       base_q;
    logic         reach;

    assign reach = ((base_q == BASE_US) ? us : cyc) >= alarm_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q <= '0;
            base_q  <= BASE_CYC;
        end else if (arm) begin
            alarm_q <= arm_value;
            base_q  <= arm_base;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (arm) state_d = ST_ARMED;
            ST_ARMED: begin
                if (arm)        state_d = ST_ARMED;
                else if (reach) state_d = ST_FIRED;
            end
            ST_FIRED: begin
                if (arm)      state_d = ST_ARMED;
                else if (ack) state_d = ST_IDLE;
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        irq = (state_q == ST_FIRED);
    end
endmodule

// File: rtl/rtc_timer.sv
module rtc_timer
    import rtc_pkg::*;
#(
    parameter int BUS_W   = 32,
    parameter int CLK_MHZ = 100,
    parameter logic [2*BUS_W-1:0] CYC_INIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    input  logic              irq_ack,
    output logic              irq
);
    localparam int CNT_W = 2 * BUS_W;

    logic [CNT_W-1:0] cyc_cnt, us_cnt;
    logic             us_tick;
    logic [BUS_W-1:0] shadow_q [2];
    logic [BUS_W-1:0] pend_q   [2];
    logic             aligned, sel_hi;
    tbase_t           sel_base;
    logic             arm;

    rtc_prescaler #(.DIV(CLK_MHZ)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick(us_tick)
    );

    rtc_counter #(.W(CNT_W), .INIT(CYC_INIT)) u_cyc (
        .clk(clk), .rst_n(rst_n), .en(1'b1), .value(cyc_cnt)
    );

    rtc_counter #(.W(CNT_W), .INIT('0)) u_us (
        .clk(clk), .rst_n(rst_n), .en(us_tick), .value(us_cnt)
    );

    assign aligned  = (addr[1:0] == 2'b00);
    assign sel_hi   = addr[HALF_BIT];
    assign sel_base = tbase_t'(addr[BASE_BIT]);
    assign arm      = wr_en && aligned && sel_hi;

    // per-base shadow and pending registers
    for (genvar b = 0; b < 2; b++) begin : g_base
        logic [CNT_W-1:0] live;
        assign live = (b == 0) ? cyc_cnt : us_cnt;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shadow_q[b] <= '0;
                pend_q[b]   <= '0;
            end else begin
                if (rd_en && aligned && !sel_hi && (int'(sel_base) == b))
                    shadow_q[b] <= live[CNT_W-1:BUS_W];
                if (wr_en && aligned && !sel_hi && (int'(sel_base) == b))
                    pend_q[b] <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en && aligned) begin
            if (sel_hi)                   rdata <= shadow_q[sel_base];
            else if (sel_base == BASE_US) rdata <= us_cnt[BUS_W-1:0];
            else                          rdata <= cyc_cnt[BUS_W-1:0];
        end
    end

    rtc_alarm_fsm #(.W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .arm_base  (sel_base),
        .arm_value ({wdata, pend_q[sel_base]}),
        .ack       (irq_ack),
        .cyc       (cyc_cnt),
        .us        (us_cnt),
        .irq       (irq)
    );
endmodule

// File: rtl/rtc_timer_chk.sv
module rtc_timer_chk #(
    parameter int BUS_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [3:0]         addr,
    input logic               wr_en,
    input logic               rd_en,
    input logic [BUS_W-1:0]   rdata,
    input logic               irq_ack,
    input logic               irq,
    input logic [2*BUS_W-1:0] cyc,
    input logic [2*BUS_W-1:0] us
);
    logic hi_wr, lo_wr;
    assign hi_wr = wr_en && (addr[1:0] == 2'b00) && addr[2];
    assign lo_wr = wr_en && (addr[1:0] == 2'b00) && !addr[2];

    assert_cyc_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cyc == $past(cyc) + 1'b1));

    assert_us_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((us == $past(us)) || (us == $past(us) + 1'b1)));

    assert_lo_write_no_raise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_wr && irq && !irq_ack) |=> irq);

    assert_arm_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hi_wr |=> !irq);

    assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack && !hi_wr) |=> irq);

    assert_ack_lowers_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && irq_ack) |=> !irq);

    assert_rdata_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

bind rtc_timer rtc_timer_chk #(.BUS_W(BUS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .rdata(rdata), .irq_ack(irq_ack), .irq(irq), .cyc(cyc_cnt), .us(us_cnt)
);

// File: tb/rtc_timer_test.sv
module rtc_timer_test;
    localparam logic [63:0] INIT = 64'h0000_0000_FFFF_FF80;
    localparam int MHZ = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0, irq_ack = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    always #5 clk = ~clk;

    rtc_timer #(.CYC_INIT(INIT), .CLK_MHZ(MHZ)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .irq_ack(irq_ack), .irq(irq)
    );

    longint unsigned edges = 0;
    always @(posedge clk) if (rst_n) edges <= edges + 1;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_pend = 1'b0;
    logic [31:0] sh_cyc = '0, sh_us = '0;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: compares read data the cycle after the strobe
    always @(posedge clk) rd_pend <= rd_en;
    always @(negedge clk) begin
        if (rd_pend && exp_q.size() > 0) begin
            chk(rdata, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    // driver: kind 0 cyc lo, 1 cyc hi, 2 us lo, 3 us hi
    task automatic rd(input int kind, input string tag);
        logic [63:0] v;
        logic [31:0] e;
        @(negedge clk);
        addr = 4'(kind * 4);
        rd_en = 1'b1;
        case (kind)
            0: begin v = INIT + edges; e = v[31:0]; sh_cyc = v[63:32]; end
            1: e = sh_cyc;
            2: begin v = edges / MHZ; e = v[31:0]; sh_us = v[63:32]; end
            default: e = sh_us;
        endcase
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] a;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk({31'd0, irq}, 32'd0, "R8 irq after reset");
        chk(rdata, 32'd0, "R8 rdata after reset");

        // R1 / R2 / R3 plain reads
        rd(0, "R1 cycle low");
        rd(1, "R1 cycle high via R3");
        rd(2, "R2 usec low");
        rd(3, "R2 usec high via R3");

        // R3 carry between low and high read
        rd(0, "R3 low before carry");
        while (edges < 140) @(negedge clk);
        rd(1, "R3 high keeps pre-carry shadow");
        chk(sh_cyc, 32'd0, "R3 model shadow is zero");
        rd(0, "R3 low after carry");
        rd(1, "R3 high after carry");
        chk(sh_cyc, 32'd1, "R3 model shadow is one");

        // R4 low write alone does not arm
        wr(4'h0, 32'd5);
        idle(20);
        chk({31'd0, irq}, 32'd0, "R4 low write leaves irq low");

        // R6 past alarm {0,5}: fires the edge after arming edge
        wr(4'h4, 32'd0);
        chk({31'd0, irq}, 32'd0, "R6 not yet raised");
        @(negedge clk);
        chk({31'd0, irq}, 32'd1, "R6 past alarm fires");

        // R7 hold, R4 low write while raised
        idle(10);
        chk({31'd0, irq}, 32'd1, "R7 irq held");
        wr(4'h0, 32'd7);
        chk({31'd0, irq}, 32'd1, "R4 low write keeps irq");
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        chk({31'd0, irq}, 32'd0, "R7 ack lowers irq");
        idle(10);
        chk({31'd0, irq}, 32'd0, "R7 disarmed after ack");

        // R5 / R6 future cycle alarm, exact edge
        a = INIT + edges + 80;
        wr(4'h0, a[31:0]);
        wr(4'h4, a[63:32]);
        while (edges != a - INIT) @(negedge clk);
        chk({31'd0, irq}, 32'd0, "R6 cycle alarm not early");
        @(negedge clk);
        chk({31'd0, irq}, 32'd1, "R5 R6 cycle alarm fires on time");

        // R5 rearm to far future clears irq
        wr(4'h0, 32'd0);
        chk({31'd0, irq}, 32'd1, "R4 pending write no effect");
        wr(4'h4, 32'd2);
        chk({31'd0, irq}, 32'd0, "R5 high write clears irq");
        idle(20);
        chk({31'd0, irq}, 32'd0, "R5 far alarm stays quiet");

        // R2 / R6 microsecond alarm
        a = edges / MHZ + 3;
        wr(4'h8, a[31:0]);
        wr(4'hC, 32'd0);
        while (edges != a * MHZ) @(negedge clk);
        chk({31'd0, irq}, 32'd0, "R2 usec alarm not early");
        @(negedge clk);
        chk({31'd0, irq}, 32'd1, "R2 R6 usec alarm fires on time");
        rd(2, "R2 usec low later");
        rd(3, "R2 usec high later");

        // R8 misaligned read ignored
        @(negedge clk); addr = 4'h1; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        chk(rdata, 32'd0, "R8 misaligned read leaves rdata");

        idle(3);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule